// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block carries out the eight block port-transfer operations of an 8-bit processor. The decoder has already consumed the 0xED prefix. It then presents the second opcode byte together with the current byte counter, the port number and the 16-bit memory pointer, and pulses `start`. Each iteration moves one byte in one of two ways:

- **Input:** from the port selected by the port number into memory at the pointer.
- **Output:** from memory at the pointer out to that port.

After the byte moves, the counter drops by one and the pointer steps up or down by one. The repeating forms keep iterating until the counter reaches zero.

One clock equals one T-state. An iteration lasts the long count when another iteration follows, and the short count otherwise. When the sequence ends, the block pulses `done` and presents the updated counter, pointer and flag byte. The processor writes these back to its register file. Memory and port reads are combinational: read data is taken in the same cycle as the read strobe.

Top module: `bio_seq`

## Requirements
- R1: Only second-byte values 0xA2, 0xAA, 0xB2, 0xBA (input) and 0xA3, 0xAB, 0xB3, 0xBB (output) start a sequence. In these values, bit 0 selects output, bit 3 selects pointer decrement and bit 4 selects repetition. A `start` with any other value is ignored: `busy` stays low, no strobe appears and `b_out` keeps its value.
- R2: An input iteration issues one port read with `port_addr` equal to the port number. It then issues one memory write of that same byte at the current pointer.
- R3: An output iteration issues one memory read at the current pointer. It then issues one port write of that byte to the port number.
- R4: Every iteration decrements the counter by one, modulo 256. The pointer moves by +1 (bit 3 clear) or −1 (bit 3 set), modulo 65536. Final values appear on `b_out` and `hl_out`.
- R5: A non-repeating form runs exactly one iteration. A repeating form runs iterations until the decremented counter is zero, so a starting count of 0 gives 256 iterations.
- R6: An iteration that is followed by another lasts 21 cycles; any other iteration lasts 16. `busy` is high for exactly the sum of these.
- R7: At completion, flag bit 6 (zero) is set exactly when the final counter is zero. Flag bit 1 (subtract) is set. All other flag bits, including carry at bit 0, equal `flags_in`.
- R8: `done` is high for exactly the one cycle after `busy` falls. `b_out`, `hl_out` and `flags_out` then hold until the next accepted start.
- R9: `start` while `busy` is high is ignored, and the running sequence completes unchanged.
- R10: No two strobes are ever active in the same cycle. Within each iteration the read strobe precedes the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted only when idle and opcode valid) |
| opcode | input | 8 | Second opcode byte |
| b_in | input | 8 | Starting byte counter |
| c_in | input | 8 | Port number |
| hl_in | input | 16 | Starting memory pointer |
| flags_in | input | 8 | Flag byte before the operation |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| b_out | output | 8 | Working/final counter |
| hl_out | output | 16 | Working/final pointer |
| flags_out | output | 8 | Final flag byte |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, combinational |
| port_addr | output | 8 | Port address |
| port_rd | output | 1 | Port read strobe |
| port_wr | output | 1 | Port write strobe |
| port_wdata | output | 8 | Port write data |
| port_rdata | input | 8 | Port read data, combinational |

## Verification
The bench starts a repeating output with a count of zero. A design that tests the counter before decrementing would finish at once instead of running 256 iterations. A repeating input starts two below the top of the address space, so a pointer that saturates or carries into stray bits shows up as wrong write addresses. Single-shot forms run with counts of one and five, and with carry set and clear, so that a design that always sets zero, or clobbers carry, gets caught. A second start arriving mid-run checks that a design which reloads its registers while busy is detected, and busy-cycle counts expose an iteration charged with the wrong length.

// File: rtl/bio_pkg.sv
package bio_pkg;

   typedef struct packed {
      logic valid;
      logic out_dir;
      logic step_dn;
      logic rep;
   } xfer_mode_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_t;

   localparam int unsigned FLAG_Z_BIT = 6;
   localparam int unsigned FLAG_N_BIT = 1;

endpackage

// File: rtl/bio_decode.sv
module bio_decode
   import bio_pkg::*;
#(
   parameter bit STRICT = 1'b1
) (
   input  logic [7:0] opcode,
   output xfer_mode_t mode
);

   logic hit;

   generate
      if (STRICT) begin : g_strict
         assign hit = (opcode[7:5] == 3'b101) && (opcode[2:1] == 2'b01);
      end else begin : g_loose
         assign hit = opcode[7] && !opcode[6] && opcode[1];
      end
   endgenerate

   always_comb begin
      mode.valid   = hit;
      mode.out_dir = opcode[0];
      mode.step_dn = opcode[3];
      mode.rep     = opcode[4];
   end

endmodule

// File: rtl/bio_timer.sv
module bio_timer #(
   parameter int T_LONG  = 21,
   parameter int T_SHORT = 16,
   parameter int RD_T    = 3,
   parameter int WR_T    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic more,
   output logic rd_slot,
   output logic wr_slot,
   output logic last
);

   localparam int TW = $clog2(T_LONG + 1);
   localparam logic [TW-1:0] END_LONG  = TW'(T_LONG - 1);
   localparam logic [TW-1:0] END_SHORT = TW'(T_SHORT - 1);
   localparam logic [TW-1:0] RD_POS    = TW'(RD_T);
   localparam logic [TW-1:0] WR_POS    = TW'(WR_T);

   generate
      if (T_SHORT > T_LONG) begin : g_bad_len
         $error("bio_timer: short iteration longer than long iteration");
      end
      if (RD_T >= WR_T) begin : g_bad_order
         $error("bio_timer: read slot must precede write slot");
      end
      if (WR_T >= T_SHORT - 1) begin : g_bad_wr
         $error("bio_timer: write slot must precede the final cycle");
      end
   endgenerate

   logic [TW-1:0] t_q;
   logic [TW-1:0] t_end;

   assign t_end   = more ? END_LONG : END_SHORT;
   assign last    = run && (t_q == t_end);
   assign rd_slot = run && (t_q == RD_POS);
   assign wr_slot = run && (t_q == WR_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q <= '0;
      end else if (!run || last) begin
         t_q <= '0;
      end else begin
         t_q <= t_q + 1'b1;
      end
   end

endmodule

// File: rtl/bio_datapath.sv
module bio_datapath
   import bio_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8,
   parameter int PORT_W = 8,
   parameter int FLAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  xfer_mode_t        mode_in,
   input  logic [CNT_W-1:0]  b_in,
   input  logic [PORT_W-1:0] c_in,
   input  logic [ADDR_W-1:0] hl_in,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic              capture,
   input  logic              step,
   input  logic              finish,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] port_rdata,
   output logic              out_dir,
   output logic              rep,
   output logic [CNT_W-1:0]  b_q,
   output logic [PORT_W-1:0] c_q,
   output logic [ADDR_W-1:0] hl_q,
   output logic [FLAG_W-1:0] flags_q,
   output logic [DATA_W-1:0] dbuf_q,
   output logic              b_zero
);

   generate
      if (FLAG_W <= FLAG_Z_BIT) begin : g_bad_flags
         $error("bio_datapath: flag byte too narrow");
      end
   endgenerate

   logic step_dn;
   logic [ADDR_W-1:0] hl_next;

   assign b_zero  = (b_q == '0);
   assign hl_next = step_dn ? (hl_q - 1'b1) : (hl_q + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_dir <= 1'b0;
         step_dn <= 1'b0;
         rep     <= 1'b0;
         b_q     <= '0;
         c_q     <= '0;
         hl_q    <= '0;
         flags_q <= '0;
         dbuf_q  <= '0;
      end else if (load) begin
         out_dir <= mode_in.out_dir;
         step_dn <= mode_in.step_dn;
         rep     <= mode_in.rep;
         b_q     <= b_in;
         c_q     <= c_in;
         hl_q    <= hl_in;
         flags_q <= flags_in;
      end else begin
         if (capture) begin
            dbuf_q <= out_dir ? mem_rdata : port_rdata;
         end
         if (step) begin
            b_q  <= b_q - 1'b1;
            hl_q <= hl_next;
         end
         if (finish) begin
            flags_q[FLAG_Z_BIT] <= b_zero;
            flags_q[FLAG_N_BIT] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/bio_seq.sv
module bio_seq
   import bio_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 8,
   parameter int PORT_W  = 8,
   parameter int FLAG_W  = 8,
   parameter int T_LONG  = 21,
   parameter int T_SHORT = 16,
   parameter int RD_T    = 3,
   parameter int WR_T    = 8,
   parameter bit STRICT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [CNT_W-1:0]  b_in,
   input  logic [PORT_W-1:0] c_in,
   input  logic [ADDR_W-1:0] hl_in,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  b_out,
   output logic [ADDR_W-1:0] hl_out,
   output logic [FLAG_W-1:0] flags_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [PORT_W-1:0] port_addr,
   output logic              port_rd,
   output logic              port_wr,
   output logic [DATA_W-1:0] port_wdata,
   input  logic [DATA_W-1:0] port_rdata
);

   seq_state_t state_q;
   xfer_mode_t dec_mode;
   logic accept, more, last, rd_slot, wr_slot, finish;
   logic out_dir, rep, b_zero;
   logic [DATA_W-1:0] dbuf;

   bio_decode #(.STRICT(STRICT)) u_dec (
      .opcode (opcode),
      .mode   (dec_mode)
   );

   assign busy   = (state_q == ST_RUN);
   assign accept = (state_q == ST_IDLE) && start && dec_mode.valid;
   assign more   = rep && !b_zero;
   assign finish = last && !more;

   bio_timer #(
      .T_LONG  (T_LONG),
      .T_SHORT (T_SHORT),
      .RD_T    (RD_T),
      .WR_T    (WR_T)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .more    (more),
      .rd_slot (rd_slot),
      .wr_slot (wr_slot),
      .last    (last)
   );

   bio_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .PORT_W (PORT_W),
      .FLAG_W (FLAG_W)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .mode_in    (dec_mode),
      .b_in       (b_in),
      .c_in       (c_in),
      .hl_in      (hl_in),
      .flags_in   (flags_in),
      .capture    (rd_slot),
      .step       (wr_slot),
      .finish     (finish),
      .mem_rdata  (mem_rdata),
      .port_rdata (port_rdata),
      .out_dir    (out_dir),
      .rep        (rep),
      .b_q        (b_out),
      .c_q        (port_addr),
      .hl_q       (hl_out),
      .flags_q    (flags_out),
      .dbuf_q     (dbuf),
      .b_zero     (b_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         done <= busy && finish;
         case (state_q)
            ST_IDLE: if (accept) state_q <= ST_RUN;
            ST_RUN:  if (finish) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr   = hl_out;
   assign mem_wdata  = dbuf;
   assign port_wdata = dbuf;
   assign mem_rd     = rd_slot && out_dir;
   assign port_rd    = rd_slot && !out_dir;
   assign mem_wr     = wr_slot && !out_dir;
   assign port_wr    = wr_slot && out_dir;

endmodule

// File: rtl/bio_seq_chk.sv
module bio_seq_chk
   import bio_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int FLAG_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              port_rd,
   input logic              port_wr,
   input logic [CNT_W-1:0]  b_out,
   input logic [FLAG_W-1:0] flags_out
);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mem_rd, mem_wr, port_rd, port_wr}) <= 1); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_rd || mem_wr || port_rd || port_wr)); // R1

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(b_out)); // R8

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FLAG_Z_BIT] == (b_out == '0))); // R7

   AST_SUB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> flags_out[FLAG_N_BIT]); // R7

endmodule

bind bio_seq bio_seq_chk #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/bio_seq_test.sv
`timescale 1ns/1ps
module bio_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [7:0]  b_in = 8'h00;
   logic [7:0]  c_in = 8'h00;
   logic [15:0] hl_in = 16'h0000;
   logic [7:0]  flags_in = 8'h00;
   logic        busy, done;
   logic [7:0]  b_out, flags_out;
   logic [15:0] hl_out, mem_addr;
   logic        mem_rd, mem_wr, port_rd, port_wr;
   logic [7:0]  mem_wdata, mem_rdata, port_addr, port_wdata, port_rdata;

   int checks = 0;
   int errors = 0;
   int pcount = 0;
   logic [7:0]  mem [0:65535];
   logic [24:0] expq [$];

   always #4 clk = ~clk;

   bio_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .b_in(b_in), .c_in(c_in), .hl_in(hl_in), .flags_in(flags_in),
      .busy(busy), .done(done), .b_out(b_out), .hl_out(hl_out),
      .flags_out(flags_out), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .port_addr(port_addr), .port_rd(port_rd), .port_wr(port_wr),
      .port_wdata(port_wdata), .port_rdata(port_rdata)
   );

   assign mem_rdata  = mem[mem_addr];
   assign port_rdata = 8'(pcount + 'h40);

   always @(posedge clk) begin
      if (port_rd) pcount <= pcount + 1;
      if (mem_wr)  mem[mem_addr] <= mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Monitor: pops expected transfers as the design writes
   always @(negedge clk) begin
      if (rst_n) begin
         if ($countones({mem_rd, mem_wr, port_rd, port_wr}) > 1)
            chk("R10", 32'($countones({mem_rd, mem_wr, port_rd, port_wr})), 1, "strobes at once");
         if (mem_wr || port_wr) begin
            logic [24:0] act;
            act = port_wr ? {1'b1, 8'h00, port_addr, port_wdata}
                          : {1'b0, mem_addr, mem_wdata};
            if (expq.size() == 0) begin
               chk(port_wr ? "R3" : "R2", 32'(act), 32'h1ffffff, "unexpected write");
            end else begin
               chk(port_wr ? "R3" : "R2", 32'(act), 32'(expq.pop_front()), "write item");
            end
         end
      end
   end

   task automatic run_xfer(input logic [7:0] op, input logic [7:0] b0,
                           input logic [7:0] c0, input logic [15:0] hl0,
                           input logic [7:0] fl0, input bit poke);
      int n, cyc, cyc_exp, pbase;
      logic [15:0] a;
      logic [7:0] bfin, flexp;
      n = op[4] ? ((b0 == 8'h00) ? 256 : int'(b0)) : 1;
      pbase = pcount;
      a = hl0;
      cyc_exp = 0;
      for (int k = 0; k < n; k++) begin
         if (op[0]) expq.push_back({1'b1, 8'h00, c0, mem[a]});
         else       expq.push_back({1'b0, a, 8'(pbase + k + 'h40)});
         cyc_exp += (k < n - 1) ? 21 : 16;
         a = op[3] ? a - 16'd1 : a + 16'd1;
      end
      bfin  = b0 - 8'(n);
      flexp = (fl0 & 8'hBD) | 8'h02 | ((bfin == 8'h00) ? 8'h40 : 8'h00);
      start = 1'b1; opcode = op; b_in = b0; c_in = c0; hl_in = hl0; flags_in = fl0;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done) begin
         if (busy) cyc++;
         if (poke && cyc == 5) begin
            start = 1'b1; opcode = 8'hBB; b_in = 8'h09; hl_in = 16'h1234;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R8", 32'(done), 1, "done after busy falls");
      chk("R4", 32'(b_out), 32'(bfin), "final counter");
      chk("R4", 32'(hl_out), 32'(a), "final pointer");
      chk("R7", 32'(flags_out), 32'(flexp), "flags");
      chk("R6", 32'(cyc), 32'(cyc_exp), "busy cycles");
      chk("R5", 32'(expq.size()), 0, "transfers left");
      if (poke) chk("R9", 32'(hl_out), 32'(a), "pointer after mid-run start");
      @(negedge clk);
      chk("R8", 32'(done), 0, "done one cycle");
      chk("R8", 32'(b_out), 32'(bfin), "counter held");
   endtask

   task automatic try_bad(input logic [7:0] op);
      logic [7:0] bprev;
      bprev = b_out;
      start = 1'b1; opcode = op; b_in = 8'h33;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 6; i++) begin
         chk("R1", 32'({busy, mem_rd, mem_wr, port_rd, port_wr}), 0, "invalid opcode idle");
         @(negedge clk);
      end
      chk("R1", 32'(b_out), 32'(bprev), "counter untouched");
   endtask

   initial begin
      for (int i = 0; i < 65536; i++) mem[i] = 8'(i[7:0] ^ i[15:8] ^ 8'h5A);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", 32'({busy, done}), 0, "reset busy/done");
      chk("R10", 32'({mem_rd, mem_wr, port_rd, port_wr}), 0, "reset strobes");
      chk("R4", 32'({b_out, hl_out}), 0, "reset registers");

      run_xfer(8'hA2, 8'h05, 8'h12, 16'h8000, 8'hFF, 1'b0); // R2 single input, inc
      run_xfer(8'hAA, 8'h01, 8'h13, 16'h8100, 8'h00, 1'b0); // R7 zero reached
      run_xfer(8'hB2, 8'h04, 8'h14, 16'hFFFE, 8'h01, 1'b0); // R4 wrap, R5 repeat
      run_xfer(8'hBA, 8'h03, 8'h15, 16'h9000, 8'h94, 1'b0);
      run_xfer(8'hA3, 8'h02, 8'h77, 16'h0010, 8'h01, 1'b0); // R3 single output
      run_xfer(8'hAB, 8'h01, 8'h78, 16'h0000, 8'hFE, 1'b0); // R4 wrap down
      run_xfer(8'hB3, 8'h03, 8'h79, 16'h0100, 8'h28, 1'b1); // R9 mid-run start
      run_xfer(8'hBB, 8'h00, 8'h7A, 16'h2000, 8'h00, 1'b0); // R5 256 iterations
      try_bad(8'hA0);
      try_bad(8'hED);
      try_bad(8'hB1);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule